// File: doc/BRIEF.md
# Audio Bit Clock Rate Generator

This block produces the serial bit clocks for an audio converter pair, one for the ADC side and one for the DAC side, when the converter is the clock master. Both clocks come from the master clock (`mclk`). A frame-boundary pulse (`frame_sync`) from the frame-clock generator marks where a new rate setting may take effect. The two outputs are always identical and in phase.

A two-bit rate select picks the bit clock. In standard interface mode, codes 00 and 01 give MCLK/4. In DSP mode, the same codes give MCLK itself. Code 10 gives 64 bit clocks per sample period and code 11 gives 128. The divisor for these two codes comes from the MCLK-to-sample-rate ratio. An error flag reports a setting that cannot be built. It also reports the DSP-mode cases where the word does not fit in the frame. A setting in error is never applied, so the previous clock keeps running.

All pins here are plain control and status pins. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `abcg_bclk_gen`

## Requirements
- R1: While `rst_n` is low, both bit clocks and `cfg_err` are 0. From reset, the applied setting is standard mode with code 00 (a period of 4 MCLK). It stays in place until a valid setting is applied at a `frame_sync`, whatever the inputs are.
- R2: In standard mode (`dsp_mode`=0), codes 00 and 01 give a bit clock with a period of 4 MCLK: 2 cycles high, then 2 low.
- R3: In DSP mode (`dsp_mode`=1), codes 00 and 01 pass `mclk` straight to both bit clocks.
- R4: Code 10 divides MCLK by `fs_ratio`/64, and code 11 divides it by `fs_ratio`/128. An even divisor gives a 50% duty cycle.
- R5: For an odd divisor d, the clock is high for (d+1)/2 cycles and low for (d-1)/2 cycles. A divisor of 1 passes `mclk` through.
- R6: `adc_bclk` and `dac_bclk` are identical at all times.
- R7: In DSP mode, `cfg_err` is raised when `fs_ratio`=128 and `word_len`>16. It is also raised when `fs_ratio`=192 and `word_len`>24. With `word_len` at or below the limit, the setting is legal.
- R8: For codes 10 and 11, `cfg_err` is raised when the divisor is not an integer or is 0. A setting with `cfg_err` raised is not applied at `frame_sync`, and the previous clock keeps running.
- R9: A new setting takes effect only in the cycle that `frame_sync` is high. On that edge, the bit clock restarts with its high phase.
- R10: `cfg_err` is registered. It reflects the inputs one MCLK edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | One-cycle frame-boundary pulse |
| rate_sel | input | 2 | Bit clock rate code |
| dsp_mode | input | 1 | 1 = DSP interface mode, 0 = standard |
| fs_ratio | input | RATIO_W (11) | MCLK cycles per sample period |
| word_len | input | WL_W (6) | Audio word length in bits |
| adc_bclk | output | 1 | ADC bit clock |
| dac_bclk | output | 1 | DAC bit clock |
| cfg_err | output | 1 | Requested setting is unsupported |

## Verification
A wrong applied divisor shows up at the ports as a bit clock with the wrong period within one period after the frame pulse. A wrong counter or duty computation shows as high and low runs of the wrong lengths. A setting in error that gets loaded anyway changes the period even though `cfg_err` is high. A setting loaded without a frame pulse changes the period in the middle of a frame. Either fault appears within one period of the next clock.

// File: rtl/abcg_pkg.sv
package abcg_pkg;
  typedef enum logic [1:0] {
    RS_MCLK_A = 2'b00,
    RS_MCLK_B = 2'b01,
    RS_FS64   = 2'b10,
    RS_FS128  = 2'b11
  } rate_sel_e;

  localparam int STD_DIV      = 4;
  localparam int FS64_SHIFT   = 6;
  localparam int FS128_SHIFT  = 7;
  localparam int DSP_RATIO_LO = 128;
  localparam int DSP_WL_LO    = 16;
  localparam int DSP_RATIO_HI = 192;
  localparam int DSP_WL_HI    = 24;
endpackage

// File: rtl/abcg_rate_decode.sv
module abcg_rate_decode
  import abcg_pkg::*;
#(
  parameter int RATIO_W = 11,
  parameter int WL_W    = 6,
  parameter int DIV_W   = 6
) (
  input  logic [1:0]         rate_sel,
  input  logic               dsp_mode,
  input  logic [RATIO_W-1:0] fs_ratio,
  input  logic [WL_W-1:0]    word_len,
  output logic [DIV_W-1:0]   div_o,
  output logic               err_o
);
  localparam logic [RATIO_W-1:0] LIM_RATIO_LO = RATIO_W'(DSP_RATIO_LO);
  localparam logic [RATIO_W-1:0] LIM_RATIO_HI = RATIO_W'(DSP_RATIO_HI);
  localparam logic [WL_W-1:0]    LIM_WL_LO    = WL_W'(DSP_WL_LO);
  localparam logic [WL_W-1:0]    LIM_WL_HI    = WL_W'(DSP_WL_HI);

  logic [RATIO_W-1:0] q64;
  logic [RATIO_W-1:0] q128;
  logic               frac64;
  logic               frac128;
  logic               rate_err;
  logic               dsp_err;

  assign q64     = fs_ratio >> FS64_SHIFT;
  assign q128    = fs_ratio >> FS128_SHIFT;
  assign frac64  = |fs_ratio[FS64_SHIFT-1:0];
  assign frac128 = |fs_ratio[FS128_SHIFT-1:0];

  // word must fit the DSP frame for the two tight ratios
  assign dsp_err = dsp_mode &&
                   (((fs_ratio == LIM_RATIO_LO) && (word_len > LIM_WL_LO)) ||
                    ((fs_ratio == LIM_RATIO_HI) && (word_len > LIM_WL_HI)));

  always_comb begin
    div_o    = DIV_W'(STD_DIV);
    rate_err = 1'b0;
    unique case (rate_sel_e'(rate_sel))
      RS_MCLK_A, RS_MCLK_B: div_o = dsp_mode ? DIV_W'(1) : DIV_W'(STD_DIV);
      RS_FS64: begin
        if (frac64 || (q64 == '0)) rate_err = 1'b1;
        else                       div_o    = DIV_W'(q64);
      end
      RS_FS128: begin
        if (frac128 || (q128 == '0)) rate_err = 1'b1;
        else                         div_o    = DIV_W'(q128);
      end
      default: rate_err = 1'b1;
    endcase
  end

  assign err_o = rate_err || dsp_err;
endmodule

// File: rtl/abcg_cfg_apply.sv
module abcg_cfg_apply
  import abcg_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             frame_sync,
  input  logic [DIV_W-1:0] req_div,
  input  logic             req_err,
  output logic [DIV_W-1:0] act_div,
  output logic             cfg_err
);
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= DIV_W'(STD_DIV);
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= req_err;
      if (frame_sync && !req_err) act_div <= req_div;
    end
  end

  a_r9_hold_between_frames: assert property (@(posedge mclk) disable iff (!rst_n)
    !frame_sync |=> $stable(act_div));
  a_r8_err_not_loaded: assert property (@(posedge mclk) disable iff (!rst_n)
    (frame_sync && req_err) |=> $stable(act_div));
  a_r10_err_follows: assert property (@(posedge mclk) disable iff (!rst_n)
    req_err |=> cfg_err);
endmodule

// File: rtl/abcg_bclk_div.sv
module abcg_bclk_div #(
  parameter int DIV_W = 6
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             bclk_q
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] hi_len;
  logic [DIV_W-1:0] cnt_nxt;

  assign hi_len  = div - (div >> 1);
  assign cnt_nxt = cnt + DIV_W'(1);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      bclk_q <= 1'b0;
    end else if (restart || (cnt >= div - DIV_W'(1))) begin
      cnt    <= '0;
      bclk_q <= 1'b1;
    end else begin
      cnt    <= cnt_nxt;
      bclk_q <= (cnt_nxt < hi_len);
    end
  end

  a_r4_cnt_range: assert property (@(posedge mclk) disable iff (!rst_n)
    (!restart && $stable(div) && (div != '0)) |=> (cnt < div));
endmodule

// File: rtl/abcg_bclk_gen.sv
module abcg_bclk_gen
  import abcg_pkg::*;
#(
  parameter int RATIO_W = 11,
  parameter int WL_W    = 6
) (
  input  logic               mclk,
  input  logic               rst_n,
  input  logic               frame_sync,
  input  logic [1:0]         rate_sel,
  input  logic               dsp_mode,
  input  logic [RATIO_W-1:0] fs_ratio,
  input  logic [WL_W-1:0]    word_len,
  output logic               adc_bclk,
  output logic               dac_bclk,
  output logic               cfg_err
);
  localparam int DIV_W  = RATIO_W - FS64_SHIFT + 1;
  localparam int N_BCLK = 2;

  logic [DIV_W-1:0]  req_div;
  logic              req_err;
  logic [DIV_W-1:0]  act_div;
  logic              bypass;
  logic [N_BCLK-1:0] div_q;
  logic [N_BCLK-1:0] bclk_out;

  abcg_rate_decode #(.RATIO_W(RATIO_W), .WL_W(WL_W), .DIV_W(DIV_W)) u_decode (
    .rate_sel (rate_sel),
    .dsp_mode (dsp_mode),
    .fs_ratio (fs_ratio),
    .word_len (word_len),
    .div_o    (req_div),
    .err_o    (req_err)
  );

  abcg_cfg_apply #(.DIV_W(DIV_W)) u_apply (
    .mclk       (mclk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .req_div    (req_div),
    .req_err    (req_err),
    .act_div    (act_div),
    .cfg_err    (cfg_err)
  );

  assign bypass = (act_div == DIV_W'(1));

  for (genvar g = 0; g < N_BCLK; g++) begin : g_bclk
    abcg_bclk_div #(.DIV_W(DIV_W)) u_div (
      .mclk    (mclk),
      .rst_n   (rst_n),
      .restart (frame_sync),
      .div     (act_div),
      .bclk_q  (div_q[g])
    );
    assign bclk_out[g] = bypass ? mclk : div_q[g];
  end

  assign adc_bclk = bclk_out[0];
  assign dac_bclk = bclk_out[1];

  a_r6_adc_dac_aligned: assert property (@(posedge mclk) disable iff (!rst_n)
    div_q[0] == div_q[1]);
  a_r9_restart_high: assert property (@(posedge mclk) disable iff (!rst_n)
    frame_sync |=> div_q[0]);
  a_r7_dsp_limit: assert property (@(posedge mclk) disable iff (!rst_n)
    (dsp_mode && (fs_ratio == RATIO_W'(DSP_RATIO_LO)) &&
     (word_len > WL_W'(DSP_WL_LO))) |=> cfg_err);
endmodule

// File: tb/abcg_bclk_gen_tb.sv
module abcg_bclk_gen_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string req;
    int    hi;
    int    lo;
    bit    err;
    bit    byp;
  } exp_t;

  logic        mclk = 0;
  logic        rst_n = 0;
  logic        frame_sync = 0;
  logic [1:0]  rate_sel = 2'b11;
  logic        dsp_mode = 0;
  logic [10:0] fs_ratio = 11'd256;
  logic [5:0]  word_len = 6'd16;
  logic        adc_bclk, dac_bclk, cfg_err;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t sb[$];

  abcg_bclk_gen u_dut (
    .mclk(mclk), .rst_n(rst_n), .frame_sync(frame_sync), .rate_sel(rate_sel),
    .dsp_mode(dsp_mode), .fs_ratio(fs_ratio), .word_len(word_len),
    .adc_bclk(adc_bclk), .dac_bclk(dac_bclk), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) mclk = ~mclk;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: set inputs, optionally pulse frame_sync, push the expectation
  task automatic drive(string req, logic [1:0] s, logic d, int r, int w,
                       bit frame, int hi, int lo, bit err, bit byp);
    exp_t e;
    while (sb.size() > 0) @(negedge mclk);
    @(negedge mclk);
    rate_sel = s; dsp_mode = d; fs_ratio = 11'(r); word_len = 6'(w);
    @(negedge mclk);
    if (frame) begin
      frame_sync = 1;
      @(negedge mclk);
      frame_sync = 0;
    end
    e.req = req; e.hi = hi; e.lo = lo; e.err = err; e.byp = byp;
    sb.push_back(e);
  endtask

  // monitor: pop each expectation and measure the outputs
  initial begin
    forever begin
      exp_t e;
      int   hi, lo, guard;
      bit   mism;
      wait (sb.size() > 0);
      e = sb[0];
      mism = 0;
      check(e.req, int'(cfg_err), int'(e.err), "cfg_err (R10)");
      if (e.byp) begin
        for (int i = 0; i < 3; i++) begin
          @(negedge mclk);
          if (adc_bclk !== 1'b0) mism = 1;
          @(posedge mclk); #1;
          if (adc_bclk !== 1'b1 || dac_bclk !== 1'b1) mism = 1;
        end
        check(e.req, int'(mism), 0, "mclk passthrough");
      end else begin
        hi = 0; lo = 0; guard = 0;
        @(negedge mclk);
        while (adc_bclk !== 1'b0 && guard < 100) begin @(negedge mclk); guard++; end
        while (adc_bclk !== 1'b1 && guard < 100) begin @(negedge mclk); guard++; end
        while (adc_bclk === 1'b1 && guard < 100) begin
          if (dac_bclk !== adc_bclk) mism = 1;
          hi++; guard++; @(negedge mclk);
        end
        while (adc_bclk === 1'b0 && guard < 100) begin
          if (dac_bclk !== adc_bclk) mism = 1;
          lo++; guard++; @(negedge mclk);
        end
        check(e.req, hi, e.hi, "high run");
        check(e.req, lo, e.lo, "low run");
        check("R6", int'(mism), 0, "adc/dac mismatch");
      end
      void'(sb.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge mclk);
    check("R1", int'(adc_bclk), 0, "adc_bclk in reset");
    check("R1", int'(dac_bclk), 0, "dac_bclk in reset");
    check("R1", int'(cfg_err), 0, "cfg_err in reset");
    rst_n = 1;
    // R1: inputs ask for code 11 at 256 but nothing is applied yet
    drive("R1", 2'b11, 0, 256, 16, 0, 2, 2, 0, 0);
    drive("R2", 2'b00, 0, 256, 16, 1, 2, 2, 0, 0);
    drive("R2", 2'b01, 0, 512, 16, 1, 2, 2, 0, 0);
    drive("R3", 2'b00, 1, 256, 16, 1, 0, 0, 0, 1);
    drive("R4", 2'b10, 0, 384, 16, 1, 3, 3, 0, 0);
    drive("R5", 2'b11, 0, 384, 16, 1, 2, 1, 0, 0);
    drive("R4", 2'b11, 0, 256, 16, 1, 1, 1, 0, 0);
    drive("R5", 2'b11, 0, 128, 16, 1, 0, 0, 0, 1);
    drive("R4", 2'b10, 0, 256, 16, 1, 2, 2, 0, 0);
    drive("R8", 2'b10, 0,  96, 16, 1, 2, 2, 1, 0);
    drive("R8", 2'b11, 0,  64, 16, 1, 2, 2, 1, 0);
    drive("R7", 2'b10, 1, 128, 24, 1, 2, 2, 1, 0);
    drive("R7", 2'b10, 1, 128, 16, 1, 1, 1, 0, 0);
    drive("R7", 2'b10, 1, 192, 32, 1, 1, 1, 1, 0);
    drive("R7", 2'b10, 1, 192, 24, 1, 2, 1, 0, 0);
    drive("R9", 2'b10, 0, 512, 16, 0, 2, 1, 0, 0);
    drive("R9", 2'b10, 0, 512, 16, 1, 4, 4, 0, 0);
    while (sb.size() > 0) @(negedge mclk);
    repeat (2) @(negedge mclk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule